// File: doc/BRIEF.md
# Crossbar element lookup unit

This combinational unit treats one register-wide operand as a small table of elements and a second operand as a vector of indices into that table. Each index is replaced by the table element it selects. An index that points past the last element produces zero and does not wrap. A single mode input chooses between 8-bit elements and 4-bit elements. Both granularities share one nibble-wide crossbar.

The register width is a parameter, and the unit is built for 32-bit or 64-bit datapaths. It sits in an execute stage next to the other integer units. The operands arrive already read from the register file, and the result goes straight to writeback. The unit holds no state, so the result follows the operands within the same cycle.

Top module: `xbar_lookup`

## Requirements
- R1: With `nib_mode_i` = 0, both operands are treated as XLEN/8 elements of 8 bits. Element 0 occupies bits [7:0] and element k occupies bits [8k+7:8k].
- R2: With `nib_mode_i` = 1, both operands are treated as XLEN/4 elements of 4 bits. Element 0 occupies bits [3:0] and element k occupies bits [4k+3:4k].
- R3: For an in-range index, output element i equals the table element whose position is the unsigned value of index element i.
- R4: In byte mode, an index value of XLEN/8 or more makes that output byte zero (4 to 255 when XLEN=32, 8 to 255 when XLEN=64).
- R5: In nibble mode, an index value of XLEN/4 or more makes that output nibble zero. This covers 8 to 15 when XLEN=32; when XLEN=64 every nibble index is in range.
- R6: The parameter XLEN accepts 32 and 64, and R1 to R5 hold at both widths.
- R7: The result depends only on the present inputs. It settles within the same cycle, and all-zero operands give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| nib_mode_i | input | 1 | Element size: 0 selects 8-bit elements, 1 selects 4-bit elements |
| table_i | input | XLEN | Table of elements to look up into |
| index_i | input | XLEN | Vector of indices, one per element position |
| result_o | output | XLEN | Looked-up elements, or zero where the index is out of range |

## Verification
The unit has no registers, so a wrong select or a wrong range decode shows on `result_o` in the same cycle as the operands that trigger it. Such faults are confined to the element positions they touch. A selector built with one bit too few appears as wrapping: an out-of-range index returns a live table element instead of zero. This is why every out-of-range index value is driven at both widths. A wrong pairing of halves in byte mode appears as swapped or duplicated nibbles inside a byte. A random table makes that distinct from a correct result.

// File: rtl/xbar_lookup.sv
module xbar_lookup #(
  parameter int XLEN = 32
) (
  input  logic            nib_mode_i,
  input  logic [XLEN-1:0] table_i,
  input  logic [XLEN-1:0] index_i,
  output logic [XLEN-1:0] result_o
);
  localparam int NN = XLEN / 4;
  localparam int NB = XLEN / 8;
  localparam int SW = $clog2(NN);

  for (genvar j = 0; j < NN; j++) begin : g_lane
    logic [7:0]    bidx;
    logic [3:0]    nidx;
    logic [SW-1:0] sel;
    logic          hit;

    assign bidx = index_i[8*(j/2) +: 8];
    assign nidx = index_i[4*j +: 4];

    always_comb begin
      if (nib_mode_i) begin
        hit = int'(nidx) < NN;
        sel = nidx[SW-1:0];
      end else begin
        hit = int'(bidx) < NB;
        sel = {bidx[SW-2:0], 1'(j % 2)};
      end
    end

    assign result_o[4*j +: 4] = hit ? table_i[4*sel +: 4] : 4'h0;
  end
endmodule

// File: rtl/xbar_lookup_chk.sv
module xbar_lookup_chk #(
  parameter int XLEN = 32
) (
  input logic            nib_mode_i,
  input logic [XLEN-1:0] table_i,
  input logic [XLEN-1:0] index_i,
  input logic [XLEN-1:0] result_o
);
  localparam int NN = XLEN / 4;
  localparam int NB = XLEN / 8;

  logic [XLEN-1:0] ident_b, ident_n;
  always_comb begin
    ident_b = '0;
    ident_n = '0;
    for (int k = 0; k < NB; k++) ident_b[8*k +: 8] = 8'(k);
    for (int k = 0; k < NN; k++) ident_n[4*k +: 4] = 4'(k);
  end

  for (genvar b = 0; b < NB; b++) begin : g_b
    always_comb
      if (!nib_mode_i && int'(index_i[8*b +: 8]) >= NB)
        AST_BYTE_OOR_ZERO: assert (result_o[8*b +: 8] == 8'h0); // R4
  end

  for (genvar j = 0; j < NN; j++) begin : g_n
    always_comb
      if (nib_mode_i && int'(index_i[4*j +: 4]) >= NN)
        AST_NIB_OOR_ZERO: assert (result_o[4*j +: 4] == 4'h0); // R5
  end

  always_comb begin
    if (table_i == '0)
      AST_ZERO_TABLE: assert (result_o == '0); // R7
    if (!nib_mode_i && index_i == ident_b)
      AST_BYTE_IDENT: assert (result_o == table_i); // R1
    if (nib_mode_i && index_i == ident_n)
      AST_NIB_IDENT: assert (result_o == table_i); // R2
  end
endmodule

bind xbar_lookup xbar_lookup_chk #(.XLEN(XLEN)) u_chk (
  .nib_mode_i(nib_mode_i),
  .table_i   (table_i),
  .index_i   (index_i),
  .result_o  (result_o)
);

// File: tb/xbar_lookup_tb.sv
module xbar_lookup_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        mode;
  logic [31:0] t32, x32, r32;
  logic [63:0] t64, x64, r64;
  int n_chk = 0, n_fail = 0;

  xbar_lookup #(.XLEN(32)) u_dut     (.nib_mode_i(mode), .table_i(t32), .index_i(x32), .result_o(r32));
  xbar_lookup #(.XLEN(64)) u_dut_w64 (.nib_mode_i(mode), .table_i(t64), .index_i(x64), .result_o(r64));

  function automatic logic [63:0] model(logic [63:0] t, logic [63:0] x, bit nib, int w);
    int esz = nib ? 4 : 8;
    int n   = w / esz;
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) begin
      int k = int'((x >> (esz * i)) & 64'((1 << esz) - 1));
      if (k < n)
        for (int b = 0; b < esz; b++) r[esz*i + b] = t[esz*k + b];
    end
    return r;
  endfunction

  task automatic run(bit nib, logic [63:0] ta, logic [63:0] xa, logic [63:0] tb_, logic [63:0] xb, string req);
    logic [63:0] e32, e64;
    @(negedge clk);
    mode = nib; t32 = ta[31:0]; x32 = xa[31:0]; t64 = tb_; x64 = xb;
    #1;
    e32 = model({32'h0, ta[31:0]}, {32'h0, xa[31:0]}, nib, 32);
    e64 = model(tb_, xb, nib, 64);
    n_chk += 2;
    if (r32 !== e32[31:0]) begin
      n_fail++;
      $display("FAIL %s w32 mode=%0d actual=%h expected=%h", req, nib, r32, e32[31:0]);
    end
    if (r64 !== e64) begin
      n_fail++;
      $display("FAIL %s w64 mode=%0d actual=%h expected=%h", req, nib, r64, e64);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] ta, tb_;
    void'($urandom(32'h5eed1));
    mode = 0; t32 = '0; x32 = '0; t64 = '0; x64 = '0;
    // R7: all-zero operands
    run(0, 0, 0, 0, 0, "R7");
    run(1, 0, 0, 0, 0, "R7");
    // R1 R2: identity index vectors return the table
    run(0, 64'hA1B2C3D4, 64'h03020100, 64'h1122334455667788, 64'h0706050403020100, "R1");
    run(1, 64'hA1B2C3D4, 64'h76543210, 64'h1122334455667788, 64'hFEDCBA9876543210, "R2");
    // R3: reversal and broadcast
    run(0, 64'hA1B2C3D4, 64'h00010203, 64'h1122334455667788, 64'h0001020304050607, "R3");
    run(1, 64'h9ABCDEF0, 64'h55555555, 64'h0123456789ABCDEF, 64'hCCCCCCCCCCCCCCCC, "R3");
    // R4: every byte index value, all lanes
    for (int v = 0; v < 256; v++) begin
      ta = rnd64(); tb_ = rnd64();
      run(0, ta, {8{8'(v)}}, tb_, {8{8'(v)}}, "R4");
    end
    // R5: every nibble index value, all lanes
    for (int v = 0; v < 16; v++) begin
      ta = rnd64(); tb_ = rnd64();
      run(1, ta, {16{4'(v)}}, tb_, {16{4'(v)}}, "R5");
    end
    // R3 R6: random operands, both modes, both widths
    for (int i = 0; i < 1500; i++) begin
      run(1'(i % 2), rnd64(), rnd64(), rnd64(), rnd64(), "R6");
    end
    // R3: in-range byte indices
    for (int i = 0; i < 500; i++) begin
      run(0, rnd64(), rnd64() & 64'h0303030303030303, rnd64(), rnd64() & 64'h0707070707070707, "R3");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule